// File: doc/BRIEF.md
# Rolling-shutter double-sampling row sequencer

This block sequences row-by-row readout of a current-mode pixel matrix in rolling order. For the active row it raises that row's gate enable and collects one digitized sample from every column, which holds signal plus pedestal. It then pulses a clear strobe to empty the pixels and waits for a settle interval. Next it collects every column a second time, which gives the pedestal alone. For each pixel it emits the first sample minus the second, tagged with its row and column.

The first pass is held in a per-column buffer, so each second-pass sample is subtracted from its own column. Differences are signed and one bit wider than the samples, so noise that drives a result below zero keeps its sign. Rows advance one at a time and wrap from the last row to row 0. A stop request is honoured only when a row has finished. Output pixels use a valid/ready handshake. While the output register is full, no second-pass sample is requested.

Top module: `rs_cds_sequencer`

## Requirements
- R1: At most one bit of `row_en_o` is high in any cycle, and all bits are low while the sequencer is idle.
- R2: After a row's gate enable rises, `smp_req_o` stays high until exactly COLS first-pass samples have been accepted, with `smp_col_o` counting 0 to COLS-1. A sample is accepted in a cycle where both `smp_req_o` and `smp_valid_i` are high. The second pass walks the columns in the same order.
- R3: Once the first pass is complete, `clear_o` is high for exactly CLEAR_CYC consecutive cycles, and `smp_req_o` is low throughout. After `clear_o` falls, `smp_req_o` stays low for SETTLE_CYC cycles. Any further wait is allowed only while the output is stalled.
- R4: Each output value `pix_data_o` is the two's-complement 17-bit result of first sample minus second sample for the same row and column. For example, 0xFFFF minus 0 gives +65535 and 0 minus 0xFFFF gives -65535.
- R5: Each output carries the row and column of its pixel in `pix_row_o` and `pix_col_o`. `pix_sof_o` is high exactly on the output for row 0, column 0.
- R6: After row r, the next active row is (r+1) modulo ROWS. A start from idle always begins at row 0.
- R7: Each row's gate enable stays high for at least ROW_MIN_CYC cycles.
- R8: While idle, `clear_o` and `smp_req_o` are low and a stop request has no effect. A stop request made during a row takes effect only after that row's second pass is complete, after which all gate enables drop.
- R9: While `pix_valid_o` is high and `pix_ready_i` is low, the output and its tags hold steady. A start request while running has no effect on the row order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin scanning at row 0 (used when idle) |
| stop_i | input | 1 | Stop at the next row boundary |
| smp_data_i | input | SAMPLE_W | Digitized unsigned column sample |
| smp_valid_i | input | 1 | Sample on `smp_data_i` is valid |
| smp_req_o | output | 1 | Sample requested for column `smp_col_o` |
| smp_col_o | output | $clog2(COLS) | Column being sampled |
| row_en_o | output | ROWS | One-hot row gate enables |
| clear_o | output | 1 | Row clear strobe |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_ready_i | input | 1 | Downstream ready |
| pix_data_o | output | SAMPLE_W+1 | Signed corrected pixel value |
| pix_row_o | output | $clog2(ROWS) | Row of the output pixel |
| pix_col_o | output | $clog2(COLS) | Column of the output pixel |
| pix_sof_o | output | 1 | First pixel of a frame |

## Verification
The bench builds a 4-row, 3-column matrix with CLEAR_CYC=2, SETTLE_CYC=3 and ROW_MIN_CYC=20. A small row count makes the wrap from the last row back to row 0 and the frame-start flag appear within a few hundred cycles. The 20-cycle row floor is longer than the sampling work, so the padding interval is exercised on every row. Random valid and ready patterns stall both the sample input and the output. Crafted samples of 0xFFFF and 0 reach both ends of the signed difference range.

// File: rtl/rs_cds_sequencer.sv
`timescale 1ns/1ps
module rs_cds_sequencer #(
  parameter int ROWS        = 256,
  parameter int COLS        = 64,
  parameter int SAMPLE_W    = 16,
  parameter int CLEAR_CYC   = 2,
  parameter int SETTLE_CYC  = 2,
  parameter int ROW_MIN_CYC = 5,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic [SAMPLE_W-1:0]    smp_data_i,
  input  logic                   smp_valid_i,
  output logic                   smp_req_o,
  output logic [CW-1:0]          smp_col_o,
  output logic [ROWS-1:0]        row_en_o,
  output logic                   clear_o,
  output logic                   pix_valid_o,
  input  logic                   pix_ready_i,
  output logic signed [SAMPLE_W:0] pix_data_o,
  output logic [RW-1:0]          pix_row_o,
  output logic [CW-1:0]          pix_col_o,
  output logic                   pix_sof_o
);
  localparam int TW = $clog2(CLEAR_CYC + SETTLE_CYC + 1);
  localparam int YW = $clog2(ROW_MIN_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_S1, ST_CLR, ST_SETTLE, ST_S2, ST_PAD} state_t;

  state_t              state;
  logic [RW-1:0]       row;
  logic [CW-1:0]       col;
  logic [TW-1:0]       cnt;
  logic [YW-1:0]       row_cyc;
  logic                stop_pend;
  logic [SAMPLE_W-1:0] cbuf [COLS];
  logic                running, out_free, acc, last_col;
  logic signed [SAMPLE_W:0] diff;

  assign running   = state != ST_IDLE;
  assign out_free  = !pix_valid_o || pix_ready_i;
  assign smp_req_o = (state == ST_S1) || (state == ST_S2 && out_free);
  assign smp_col_o = col;
  assign acc       = smp_req_o && smp_valid_i;
  assign last_col  = col == CW'(COLS - 1);
  assign clear_o   = state == ST_CLR;
  assign row_en_o  = running ? (ROWS'(1) << row) : '0;
  assign diff      = $signed({1'b0, cbuf[col]}) - $signed({1'b0, smp_data_i});
  assign pix_sof_o = pix_valid_o && pix_row_o == '0 && pix_col_o == '0;

  always_ff @(posedge clk) begin
    if (state == ST_S1 && acc) cbuf[col] <= smp_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      row         <= '0;
      col         <= '0;
      cnt         <= '0;
      row_cyc     <= '0;
      stop_pend   <= 1'b0;
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
      pix_row_o   <= '0;
      pix_col_o   <= '0;
    end else begin
      if (pix_ready_i) pix_valid_o <= 1'b0;
      if (running && stop_i) stop_pend <= 1'b1;
      if (running && row_cyc < YW'(ROW_MIN_CYC)) row_cyc <= row_cyc + 1'b1;
      case (state)
        ST_IDLE: if (start_i) begin
          state     <= ST_S1;
          row       <= '0;
          col       <= '0;
          row_cyc   <= '0;
          stop_pend <= 1'b0;
        end
        ST_S1: if (acc) begin
          if (last_col) begin
            col   <= '0;
            cnt   <= '0;
            state <= ST_CLR;
          end else col <= col + 1'b1;
        end
        ST_CLR: begin
          if (cnt == TW'(CLEAR_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_SETTLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_SETTLE: begin
          if (cnt == TW'(SETTLE_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_S2;
          end else cnt <= cnt + 1'b1;
        end
        ST_S2: if (acc) begin
          pix_valid_o <= 1'b1;
          pix_data_o  <= diff;
          pix_row_o   <= row;
          pix_col_o   <= col;
          if (last_col) begin
            col   <= '0;
            state <= ST_PAD;
          end else col <= col + 1'b1;
        end
        ST_PAD: if (row_cyc >= YW'(ROW_MIN_CYC - 1)) begin
          row_cyc <= '0;
          if (stop_pend || stop_i) begin
            state     <= ST_IDLE;
            stop_pend <= 1'b0;
          end else begin
            state <= ST_S1;
            row   <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_row_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_en_o));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en_o == '0) |-> (!clear_o && !smp_req_o));

  p_clear_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> !smp_req_o);

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_ready_i) |=>
      (pix_valid_o && $stable(pix_data_o) && $stable(pix_row_o) && $stable(pix_col_o)));

  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en_o != '0 && $past(row_en_o) != '0 && row_en_o != $past(row_en_o)) |->
      (row_en_o == {$past(row_en_o[ROWS-2:0]), $past(row_en_o[ROWS-1])}));

  p_stop_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(row_en_o) != '0 && row_en_o == '0) |-> ($past(state) == ST_PAD));
endmodule

// File: tb/test_rs_cds_sequencer.sv
`timescale 1ns/1ps
module test_rs_cds_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4, COLS = 3, SW = 16;
  localparam int CLEAR_CYC = 2, SETTLE_CYC = 3, ROW_MIN_CYC = 20;
  localparam int RW = $clog2(ROWS), CW = $clog2(COLS);

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic [SW-1:0] smp_data_i = '0;
  logic smp_valid_i = 1'b0, pix_ready_i = 1'b0;
  logic smp_req_o, clear_o, pix_valid_o, pix_sof_o;
  logic [CW-1:0] smp_col_o, pix_col_o;
  logic [RW-1:0] pix_row_o;
  logic [ROWS-1:0] row_en_o;
  logic signed [SW:0] pix_data_o;

  rs_cds_sequencer #(.ROWS(ROWS), .COLS(COLS), .SAMPLE_W(SW), .CLEAR_CYC(CLEAR_CYC),
    .SETTLE_CYC(SETTLE_CYC), .ROW_MIN_CYC(ROW_MIN_CYC)) i_rs_cds_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .smp_data_i(smp_data_i), .smp_valid_i(smp_valid_i), .smp_req_o(smp_req_o),
    .smp_col_o(smp_col_o), .row_en_o(row_en_o), .clear_o(clear_o),
    .pix_valid_o(pix_valid_o), .pix_ready_i(pix_ready_i), .pix_data_o(pix_data_o),
    .pix_row_o(pix_row_o), .pix_col_o(pix_col_o), .pix_sof_o(pix_sof_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, popped = 0;
  bit active = 0;
  int exp_row = 0, s_col = 0, pass = 0, last_idx = -1, row_len = 0;
  int clr_run = 0, gap = 0, drv_data = 0;
  bit gap_act = 0, pre_clear = 0, hs_smp = 0, hs_pix = 0, held = 0;
  int held_data = 0, sn_data = 0, sn_row = 0, sn_col = 0;
  bit sn_sof = 0;
  int first [COLS];
  int q_data [$], q_row [$], q_col [$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int v1(int r, int c);
    if (r == 1 && c == 0) return 65535;
    if (r == 1 && c == 1) return 0;
    return (r * 37 + c * 1000 + 5) & 16'hFFFF;
  endfunction

  function automatic int v2(int r, int c);
    if (r == 1 && c == 0) return 0;
    if (r == 1 && c == 1) return 65535;
    return (r * 11 + c * 300 + 900) & 16'hFFFF;
  endfunction

  function automatic int idx(logic [ROWS-1:0] v);
    for (int i = 0; i < ROWS; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (active) begin
      int cur;
      if (hs_smp) begin
        if (pass == 0) first[s_col] = drv_data;
        else begin
          q_data.push_back(first[s_col] - drv_data);
          q_row.push_back(exp_row);
          q_col.push_back(s_col);
        end
        s_col++;
        if (s_col == COLS) begin s_col = 0; pass ^= 1; end
      end
      if (hs_pix) begin
        if (q_data.size() == 0) chk(0, "R4 unexpected pixel", sn_data, 0);
        else begin
          int ed, er, ec;
          ed = q_data.pop_front(); er = q_row.pop_front(); ec = q_col.pop_front();
          chk(sn_data == ed, "R4 difference", sn_data, ed);
          chk(sn_row == er, "R5 row tag", sn_row, er);
          chk(sn_col == ec, "R5 col tag", sn_col, ec);
          chk(sn_sof == (er == 0 && ec == 0), "R5 sof", int'(sn_sof), int'(er == 0 && ec == 0));
        end
        popped++;
      end
      if (held) chk(pix_valid_o && int'($signed(pix_data_o)) == held_data, "R9 hold",
                    int'($signed(pix_data_o)), held_data);
      cur = idx(row_en_o);
      chk($countones(row_en_o) <= 1, "R1 onehot", $countones(row_en_o), 1);
      if (cur != last_idx) begin
        if (last_idx >= 0) chk(row_len >= ROW_MIN_CYC, "R7 row length", row_len, ROW_MIN_CYC);
        if (cur >= 0) begin
          if (last_idx < 0) chk(cur == 0, "R6 start row", cur, 0);
          else chk(cur == (last_idx + 1) % ROWS, "R6 row order", cur, (last_idx + 1) % ROWS);
          chk(s_col == 0 && pass == 0, "R2 row complete", s_col + pass * COLS, 0);
          exp_row = cur; row_len = 1; pre_clear = 1;
        end else begin
          chk(s_col == 0 && pass == 0, "R8 stop boundary", s_col + pass * COLS, 0);
        end
        last_idx = cur;
      end else row_len++;
      if (cur < 0) chk(!clear_o && !smp_req_o, "R8 idle quiet", int'(clear_o) + int'(smp_req_o), 0);
      if (clear_o) begin
        chk(!smp_req_o, "R3 no request in clear", int'(smp_req_o), 0);
        if (pre_clear) chk(s_col == 0 && pass == 1, "R2 first pass count", s_col + pass * COLS, COLS);
        pre_clear = 0;
        clr_run++;
      end else begin
        if (clr_run > 0) begin
          chk(clr_run == CLEAR_CYC, "R3 clear width", clr_run, CLEAR_CYC);
          clr_run = 0; gap_act = 1; gap = 0;
        end
        if (pre_clear && cur >= 0) chk(smp_req_o, "R2 first pass request", int'(smp_req_o), 1);
      end
      if (gap_act && !clear_o) begin
        if (smp_req_o) begin
          chk(gap >= SETTLE_CYC, "R3 settle gap", gap, SETTLE_CYC);
          gap_act = 0;
        end else begin
          if (gap >= SETTLE_CYC) chk(pix_valid_o && !pix_ready_i, "R3 late request", gap, SETTLE_CYC);
          gap++;
        end
      end
      if (smp_req_o) chk(int'(smp_col_o) == s_col, "R2 column order", int'(smp_col_o), s_col);
      pix_ready_i = ($urandom_range(0, 99) < 70);
      smp_valid_i = ($urandom_range(0, 99) < 80);
      drv_data = pass ? v2(exp_row, s_col) : v1(exp_row, s_col);
      smp_data_i = SW'(drv_data);
      #1;
      hs_smp = smp_req_o && smp_valid_i;
      hs_pix = pix_valid_o && pix_ready_i;
      sn_data = int'($signed(pix_data_o)); sn_row = int'(pix_row_o);
      sn_col = int'(pix_col_o); sn_sof = pix_sof_o;
      held = pix_valid_o && !pix_ready_i;
      held_data = sn_data;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  task automatic pulse_start(); @(negedge clk); start_i = 1; @(negedge clk); start_i = 0; endtask
  task automatic pulse_stop();  @(negedge clk); stop_i = 1;  @(negedge clk); stop_i = 0;  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(row_en_o == '0, "R1 reset row enables", int'(row_en_o), 0);
    chk(!clear_o && !smp_req_o, "R8 reset quiet", int'(clear_o) + int'(smp_req_o), 0);
    chk(!pix_valid_o, "R9 reset valid", int'(pix_valid_o), 0);
    rst_n = 1;
    @(negedge clk);
    active = 1;
    repeat (5) @(negedge clk);
    pulse_stop();
    repeat (5) @(negedge clk);
    chk(row_en_o == '0, "R8 stop in idle", int'(row_en_o), 0);
    pulse_start();
    while (popped < 6 * COLS) @(negedge clk);
    pulse_start();
    repeat (7) @(negedge clk);
    pulse_stop();
    while (row_en_o != '0) @(negedge clk);
    repeat (30) @(negedge clk);
    pulse_stop();
    repeat (5) @(negedge clk);
    chk(row_en_o == '0 && !clear_o, "R8 still idle", int'(row_en_o), 0);
    pulse_start();
    while (popped < 11 * COLS) @(negedge clk);
    pulse_stop();
    while (row_en_o != '0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(q_data.size() == 0, "R4 all pixels out", q_data.size(), 0);
    summary();
  end
endmodule